// File: doc/BRIEF.md
# Width-Aware Register File with Opcode-Directed Destination

This block holds the five programmer-visible registers of a small microcoded datapath: four general registers (A, B, C, D) and a stack pointer (SP). Each clock edge can write one of them from the ALU result bus. A 3-bit microcode field picks the destination. One code of that field takes the register number from two opcode bits instead, so a single microcode routine can serve every general register. A width bit chooses between a full-word write and a byte write. A byte write replaces only the low byte and leaves the upper byte unchanged.

The block also holds the two ALU operand latches, X and Y. Each latch has its own 8-way source selector and its own load strobe. The selector can pick a constant zero, any of the five registers, or the memory-address and memory-data values, which arrive from outside as plain inputs. The ALU and the memory registers belong to other blocks. The current register contents are also driven onto an output bus for any neighbour that reads them.

Top module: `opreg_file`

## Requirements
- R1: While `rst_n` is low, every register and both operand latches are cleared to zero at the clock edge, whatever the other inputs are.
- R2: Destination code 3'b000 writes no register.
- R3: Destination code 3'b110 is reserved and writes no register.
- R4: Destination codes 3'b001, 3'b010, 3'b011, 3'b100 and 3'b101 write A, B, C, D and SP respectively at the next rising edge. At most one register is written per edge.
- R5: Destination code 3'b111 takes the register from `ir_reg`: 2'b00 A, 2'b01 B, 2'b10 C, 2'b11 D. SP is never written through this code.
- R6: With `wide` = 1, the selected register takes all 16 bits of `z_bus`.
- R7: With `wide` = 0, the selected register takes `z_bus[7:0]` into bits 7:0, and bits 15:8 keep their previous value.
- R8: The operand source codes are 3'b000 zero, 3'b001 A, 3'b010 B, 3'b011 C, 3'b100 D, 3'b101 SP, 3'b110 `mar_in`, 3'b111 `mdr_in`.
- R9: A load strobe captures the selected source at the rising edge, using the register value from before any write at that same edge. Without the strobe, the latch holds its value.
- R10: X and Y load independently. Each has its own source code and its own strobe.
- R11: `regs_o` carries A in bits 15:0, B in 31:16, C in 47:32, D in 63:48 and SP in 79:64, with each register's current content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| z_bus | input | 16 | ALU result, the write data |
| dest_sel | input | 3 | Destination code from microcode |
| ir_reg | input | 2 | Register number from opcode bits 7:6, used by code 3'b111 |
| wide | input | 1 | 1 = 16-bit write, 0 = low-byte write |
| mar_in | input | 16 | Memory-address register value, operand source 3'b110 |
| mdr_in | input | 16 | Memory-data register value, operand source 3'b111 |
| x_src | input | 3 | Source code for operand latch X |
| y_src | input | 3 | Source code for operand latch Y |
| x_load | input | 1 | Load strobe for X |
| y_load | input | 1 | Load strobe for Y |
| x_out | output | 16 | Operand latch X |
| y_out | output | 16 | Operand latch Y |
| regs_o | output | 80 | Current contents of A, B, C, D, SP |

## Verification
The assertions assume that every control input is a known 0 or 1 at each rising edge and that `rst_n` is held low at the first edge. Every control code, including the reserved destination, is a legal input and is expected to be handled. The stimulus drives all inputs at the falling edge from tasks and starts under reset. After that it uses only defined values. It covers every destination code, every `ir_reg` value and every source code, both with directed cases and with random draws.

// File: rtl/opreg_pkg.sv
// Shared encodings for the register file: the destination codes and the
// operand source codes used by microcode. Assumes 3-bit fields throughout.
package opreg_pkg;

    localparam int NUM_GPR  = 5;   // A, B, C, D, SP
    localparam int CODE_W   = 3;
    localparam int IDX_W    = 3;

    typedef enum logic [CODE_W-1:0] {
        DST_NONE = 3'b000,
        DST_A    = 3'b001,
        DST_B    = 3'b010,
        DST_C    = 3'b011,
        DST_D    = 3'b100,
        DST_SP   = 3'b101,
        DST_RSV  = 3'b110,
        DST_IR   = 3'b111
    } dst_code_e;

    typedef enum logic [CODE_W-1:0] {
        SRC_ZERO = 3'b000,
        SRC_A    = 3'b001,
        SRC_B    = 3'b010,
        SRC_C    = 3'b011,
        SRC_D    = 3'b100,
        SRC_SP   = 3'b101,
        SRC_MAR  = 3'b110,
        SRC_MDR  = 3'b111
    } src_code_e;

endpackage

// File: rtl/opreg_dest_decode.sv
// Turns the microcode destination code into a one-hot register write enable.
// Code 3'b111 takes the register number from the opcode bits (A..D only).
// Assumes codes are known values; the reserved code and "none" write nothing.
module opreg_dest_decode
    import opreg_pkg::*;
(
    input  logic [CODE_W-1:0]  dest_sel,
    input  logic [1:0]         ir_reg,
    output logic [NUM_GPR-1:0] wr_en
);

    // Map the destination code to a one-hot register select.
    always_comb begin
        wr_en = '0;
        case (dst_code_e'(dest_sel))
            DST_A:   wr_en[0] = 1'b1;
            DST_B:   wr_en[1] = 1'b1;
            DST_C:   wr_en[2] = 1'b1;
            DST_D:   wr_en[3] = 1'b1;
            DST_SP:  wr_en[4] = 1'b1;
            DST_IR:  wr_en[ir_reg] = 1'b1;
            default: wr_en = '0;
        endcase
    end

endmodule

// File: rtl/opreg_bank.sv
// Storage for the five registers. Each register is split into a low byte,
// written on any enabled write, and an upper part, written only on a wide
// write. Assumes at most one write enable is high per cycle.
module opreg_bank
    import opreg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_GPR-1:0]        wr_en,
    input  logic                      wide,
    input  logic [DATA_W-1:0]         wdata,
    output logic [NUM_GPR*DATA_W-1:0] regs_flat
);

    localparam int HI_W = DATA_W - BYTE_W;

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
        logic [BYTE_W-1:0] lo_q;
        logic [HI_W-1:0]   hi_q;

        // Low byte: cleared by reset, loaded on any write to this register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lo_q <= '0;
            else if (wr_en[g])
                lo_q <= wdata[BYTE_W-1:0];
        end

        // Upper part: cleared by reset, loaded only by a wide write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hi_q <= '0;
            else if (wr_en[g] && wide)
                hi_q <= wdata[DATA_W-1:BYTE_W];
        end

        assign regs_flat[g*DATA_W +: DATA_W] = {hi_q, lo_q};
    end

endmodule

// File: rtl/opreg_operand.sv
// One ALU operand latch with its own 8-way source selector. The selector
// sees the register values as they are before the current edge's write.
// Assumes the source code is a known value.
module opreg_operand
    import opreg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CODE_W-1:0]         src_sel,
    input  logic                      load,
    input  logic [NUM_GPR*DATA_W-1:0] regs_flat,
    input  logic [DATA_W-1:0]         mar_in,
    input  logic [DATA_W-1:0]         mdr_in,
    output logic [DATA_W-1:0]         q
);

    logic [DATA_W-1:0] sel_val;

    // Pick the operand value named by the source code.
    always_comb begin
        case (src_code_e'(src_sel))
            SRC_ZERO: sel_val = '0;
            SRC_A:    sel_val = regs_flat[0*DATA_W +: DATA_W];
            SRC_B:    sel_val = regs_flat[1*DATA_W +: DATA_W];
            SRC_C:    sel_val = regs_flat[2*DATA_W +: DATA_W];
            SRC_D:    sel_val = regs_flat[3*DATA_W +: DATA_W];
            SRC_SP:   sel_val = regs_flat[4*DATA_W +: DATA_W];
            SRC_MAR:  sel_val = mar_in;
            SRC_MDR:  sel_val = mdr_in;
            default:  sel_val = '0;
        endcase
    end

    // Capture the selected operand when strobed; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= sel_val;
    end

endmodule

// File: rtl/opreg_file.sv
// Top of the register file: destination decode, register storage and the
// two operand latches X and Y. Assumes a synchronous active-low reset and
// control inputs that are stable around the rising edge.
module opreg_file
    import opreg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DATA_W-1:0]         z_bus,
    input  logic [2:0]                dest_sel,
    input  logic [1:0]                ir_reg,
    input  logic                      wide,
    input  logic [DATA_W-1:0]         mar_in,
    input  logic [DATA_W-1:0]         mdr_in,
    input  logic [2:0]                x_src,
    input  logic [2:0]                y_src,
    input  logic                      x_load,
    input  logic                      y_load,
    output logic [DATA_W-1:0]         x_out,
    output logic [DATA_W-1:0]         y_out,
    output logic [NUM_GPR*DATA_W-1:0] regs_o
);

    localparam int NUM_OPS = 2;

    logic [NUM_GPR-1:0]                 wr_en;
    logic [NUM_OPS-1:0][CODE_W-1:0]     op_src;
    logic [NUM_OPS-1:0]                 op_load;
    logic [NUM_OPS-1:0][DATA_W-1:0]     op_q;

    assign op_src  = {y_src, x_src};
    assign op_load = {y_load, x_load};
    assign x_out   = op_q[0];
    assign y_out   = op_q[1];

    opreg_dest_decode u_dec (
        .dest_sel (dest_sel),
        .ir_reg   (ir_reg),
        .wr_en    (wr_en)
    );

    opreg_bank #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wide      (wide),
        .wdata     (z_bus),
        .regs_flat (regs_o)
    );

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        opreg_operand #(
            .DATA_W (DATA_W)
        ) u_op (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_sel   (op_src[g]),
            .load      (op_load[g]),
            .regs_flat (regs_o),
            .mar_in    (mar_in),
            .mdr_in    (mdr_in),
            .q         (op_q[g])
        );
    end

endmodule

// File: rtl/opreg_file_chk.sv
// Temporal checks on the register file, bound to every opreg_file instance.
// Assumes known control inputs and reset asserted at the first edge.
module opreg_file_chk
    import opreg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [DATA_W-1:0]         z_bus,
    input logic [2:0]                dest_sel,
    input logic                      wide,
    input logic [2:0]                x_src,
    input logic                      x_load,
    input logic                      y_load,
    input logic [DATA_W-1:0]         x_out,
    input logic [DATA_W-1:0]         y_out,
    input logic [NUM_GPR-1:0]        wr_en,
    input logic [NUM_GPR*DATA_W-1:0] regs_o
);

    logic [DATA_W-1:0] reg_a, reg_sp;
    assign reg_a  = regs_o[0*DATA_W +: DATA_W];
    assign reg_sp = regs_o[4*DATA_W +: DATA_W];

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (regs_o == '0 && x_out == '0 && y_out == '0));

    a_r2_none_holds: assert property (@(posedge clk) disable iff (!rst_n)
        dest_sel == 3'b000 |=> $stable(regs_o));

    a_r3_reserved_holds: assert property (@(posedge clk) disable iff (!rst_n)
        dest_sel == 3'b110 |=> $stable(regs_o));

    a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    a_r5_ir_spares_sp: assert property (@(posedge clk) disable iff (!rst_n)
        dest_sel == 3'b111 |=> $stable(reg_sp));

    a_r6_wide_write_a: assert property (@(posedge clk) disable iff (!rst_n)
        (dest_sel == 3'b001 && wide) |=> reg_a == $past(z_bus));

    a_r7_byte_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (dest_sel == 3'b001 && !wide) |=>
        (reg_a[DATA_W-1:BYTE_W] == $past(reg_a[DATA_W-1:BYTE_W]) &&
         reg_a[BYTE_W-1:0] == $past(z_bus[BYTE_W-1:0])));

    a_r8_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
        (x_load && x_src == 3'b000) |=> x_out == '0);

    a_r9_x_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !x_load |=> $stable(x_out));

    a_r10_y_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !y_load |=> $stable(y_out));

endmodule

bind opreg_file opreg_file_chk #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .z_bus    (z_bus),
    .dest_sel (dest_sel),
    .wide     (wide),
    .x_src    (x_src),
    .x_load   (x_load),
    .y_load   (y_load),
    .x_out    (x_out),
    .y_out    (y_out),
    .wr_en    (wr_en),
    .regs_o   (regs_o)
);

// File: tb/opreg_file_bench.sv
// Bench: behavioural reference model stepped once per clock and compared
// with every output after each rising edge.
module opreg_file_bench;

    localparam int W = 16;
    localparam int N = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [W-1:0]  z_bus, mar_in, mdr_in;
    logic [2:0]    dest_sel, x_src, y_src;
    logic [1:0]    ir_reg;
    logic          wide, x_load, y_load;
    logic [W-1:0]  x_out, y_out;
    logic [N*W-1:0] regs_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic [W-1:0] m_reg [N];
    logic [W-1:0] m_x, m_y;

    always #2 clk = ~clk;

    opreg_file u_opreg_file (
        .clk(clk), .rst_n(rst_n), .z_bus(z_bus), .dest_sel(dest_sel),
        .ir_reg(ir_reg), .wide(wide), .mar_in(mar_in), .mdr_in(mdr_in),
        .x_src(x_src), .y_src(y_src), .x_load(x_load), .y_load(y_load),
        .x_out(x_out), .y_out(y_out), .regs_o(regs_o)
    );

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] src_val(logic [2:0] s);
        case (s)
            3'd0: return '0;
            3'd6: return mar_in;
            3'd7: return mdr_in;
            default: return m_reg[s-1];
        endcase
    endfunction

    task automatic compare_all(string rtag, string otag);
        for (int i = 0; i < N; i++)
            check(rtag, $sformatf("reg%0d", i), regs_o[i*W +: W], m_reg[i]);
        check(otag, "x_out", x_out, m_x);
        check(otag, "y_out", y_out, m_y);
    endtask

    // One cycle: drive at the falling edge, advance the model, compare after the edge.
    task automatic step(logic [2:0] d, logic [1:0] ir, logic wd, logic [W-1:0] z,
                        logic [2:0] xs, logic [2:0] ys, logic xl, logic yl,
                        logic [W-1:0] ma, logic [W-1:0] md);
        int idx;
        logic [W-1:0] nx, ny;
        string rtag;
        dest_sel = d; ir_reg = ir; wide = wd; z_bus = z;
        x_src = xs; y_src = ys; x_load = xl; y_load = yl;
        mar_in = ma; mdr_in = md;
        nx = xl ? src_val(xs) : m_x;   // R9: old register values
        ny = yl ? src_val(ys) : m_y;
        case (d)
            3'd0: begin idx = -1; rtag = "R2"; end
            3'd6: begin idx = -1; rtag = "R3"; end
            3'd7: begin idx = int'(ir); rtag = wd ? "R5/R6" : "R5/R7"; end
            default: begin idx = int'(d) - 1; rtag = wd ? "R4/R6/R11" : "R4/R7/R11"; end
        endcase
        if (idx >= 0) begin
            if (wd) m_reg[idx] = z;
            else    m_reg[idx][7:0] = z[7:0];
        end
        m_x = nx; m_y = ny;
        @(posedge clk);
        @(negedge clk);
        compare_all(rtag, "R8/R9/R10");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset with busy inputs still clears everything.
        rst_n = 1'b0;
        dest_sel = 3'd1; ir_reg = 2'd0; wide = 1'b1; z_bus = 16'hFFFF;
        x_src = 3'd6; y_src = 3'd7; x_load = 1'b1; y_load = 1'b1;
        mar_in = 16'h1111; mdr_in = 16'h2222;
        for (int i = 0; i < N; i++) m_reg[i] = '0;
        m_x = '0; m_y = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1", "R1");
        rst_n = 1'b1;

        // R4/R6: wide writes to every register through direct codes.
        step(3'd1, 2'd0, 1'b1, 16'h1234, 3'd0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        step(3'd2, 2'd0, 1'b1, 16'h5678, 3'd0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        step(3'd3, 2'd0, 1'b1, 16'h9ABC, 3'd0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        step(3'd4, 2'd0, 1'b1, 16'hDEF0, 3'd0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        step(3'd5, 2'd0, 1'b1, 16'h0FF0, 3'd0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        // R7: byte write keeps the high byte (A becomes 12CD).
        step(3'd1, 2'd0, 1'b0, 16'hABCD, 3'd0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        // R2 and R3: no register changes.
        step(3'd0, 2'd0, 1'b1, 16'hEEEE, 3'd0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        step(3'd6, 2'd3, 1'b1, 16'hEEEE, 3'd0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        // R5: opcode-directed writes, wide and byte.
        for (int r = 0; r < 4; r++)
            step(3'd7, 2'(r), 1'(r & 1), 16'hA500 + 16'(r), 3'd0, 3'd0, 1'b0, 1'b0, 16'h0, 16'h0);
        // R8: every source into X, reversed order into Y.
        for (int s = 0; s < 8; s++)
            step(3'd0, 2'd0, 1'b1, 16'h0, 3'(s), 3'(7 - s), 1'b1, 1'b1, 16'hC0DE, 16'hBEEF);
        // R9: X loads A in the same edge A is rewritten: X gets the old value.
        step(3'd1, 2'd0, 1'b1, 16'h7777, 3'd1, 3'd0, 1'b1, 1'b0, 16'h0, 16'h0);
        // R10: only Y strobed, X holds.
        step(3'd0, 2'd0, 1'b1, 16'h0, 3'd6, 3'd7, 1'b0, 1'b1, 16'h4444, 16'h5555);
        step(3'd0, 2'd0, 1'b1, 16'h0, 3'd2, 3'd6, 1'b1, 1'b0, 16'h6666, 16'h0);

        // Random mix over all codes.
        for (int k = 0; k < 2000; k++)
            step(3'($urandom), 2'($urandom), 1'($urandom), 16'($urandom),
                 3'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
                 16'($urandom), 16'($urandom));

        finish_run();
    end

endmodule